// File: doc/BRIEF.md
# On-Deck Loop and Torpedo Execution Controller

This block sits at the head of a port's circular instruction queue and rules on the instruction currently on deck. It keeps two loop counters. The outer counter applies to every instruction. The inner counter applies only to moves, and it can also hold an "infinite" value. Each cycle the block decides whether the on-deck instruction executes, is skipped, or is cut short by a pending interrupt token (a "torpedo"). It also decides whether the instruction leaves the deck and whether a copy of it goes back into the queue.

The block guards the queue's entry with an admission hatch. A tail marker that arrives at an open hatch seals it and is not itself enqueued. The hatch reopens when a requeueable instruction is on deck while the zero indication (outer count equal to zero) is true.

Predicate evaluation and the A/B/C flags sit outside this block. The block takes a single `pred_ok` input and exports the zero indication so that the outside logic can use it.

Top module: `ondeck_exec_ctl`

## Requirements
- R1: After synchronous reset, the outer count is 0, `z_flag` is 1, the inner count is 1, `ilc_inf` is 0, `hatch_open` is 1 and `torp_in_ready` is 1.
- R2: When `od_valid` is 1 and `pred_ok` is 0, the instruction retires in the same cycle. In that case `od_exec`, `torp_take` and all counter changes are suppressed.
- R3: A move (`od_kind`=2'b00) with `od_immune`=0 and `pred_ok`=1, on deck while a torpedo is pending, behaves as follows. In the same cycle `torp_take`=1, `od_retire`=1 and `od_exec`=0. From the next cycle the outer count is 0, the inner count is 1, `ilc_inf` is 0 and `torp_in_ready` is 1.
- R4: A pending torpedo is left alone by an immune move and by any non-move kind (2'b01 set, 2'b10 shift, 2'b11 other). Those instructions execute normally, and `torp_in_ready` stays 0.
- R5: A move with inner count N≥1 and infinity clear asserts `od_exec` for N consecutive on-deck cycles and asserts `od_retire` only on the last of them. The inner count reads 1 afterwards.
- R6: A move with inner count 0 retires without executing, and the inner count becomes 1.
- R7: While `ilc_inf`=1, a move that is not torpedoed executes every cycle and never retires.
- R8: When a set instruction executes, `cnt_op` acts on the outer counter as follows. 3'd1 loads the zero-extended `cnt_imm`. 3'd2 loads the low bits of `latch_data`. 3'd3 decrements by one, holding at 0 when the count is already 0.
- R9: When a set instruction executes, `cnt_op` acts on the inner counter as follows. 3'd4 loads `cnt_imm` and clears infinity. 3'd5 sets infinity. 3'd6 loads the low bits of `latch_data` and clears infinity. Codes 3'd0 and 3'd7 change nothing.
- R10: `requeue` is 1 exactly in cycles where `od_retire`=1, `od_one_shot`=0 and the outer count before that cycle's update is nonzero.
- R11: `torp_in_ready` is 1 if and only if no torpedo is pending. A torpedo offered while ready becomes pending from the next cycle.
- R12: `enq_ready` equals `hatch_open`. `enq_push` is 1 only for a non-tail entry offered while the hatch is open. A tail offered while the hatch is open seals the hatch for the next cycle and is not pushed. Sealing wins over a same-cycle reopen condition.
- R13: A sealed hatch reopens in the next cycle when `od_valid`=1, `od_one_shot`=0 and `z_flag`=1. A one-shot instruction on deck does not reopen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| od_valid | input | 1 | An instruction is on deck |
| od_kind | input | 2 | 00 move, 01 set, 10 shift, 11 other |
| od_one_shot | input | 1 | Instruction must not be requeued |
| od_immune | input | 1 | Move cannot be interrupted by a torpedo |
| pred_ok | input | 1 | External predicate result for the on-deck instruction |
| cnt_op | input | 3 | Counter operation carried by a set instruction |
| cnt_imm | input | IMM_W | Counter immediate |
| latch_data | input | DATA_W | Current data latch contents |
| torp_in_valid | input | 1 | A torpedo is offered |
| torp_in_ready | output | 1 | The torpedo slot is empty |
| enq_valid | input | 1 | An entry is offered to the queue |
| enq_is_tail | input | 1 | The offered entry is a tail marker |
| enq_ready | output | 1 | The hatch admits entries |
| enq_push | output | 1 | Write the offered entry into the queue |
| od_exec | output | 1 | The on-deck instruction takes effect this cycle |
| od_retire | output | 1 | The on-deck instruction leaves the deck this cycle |
| torp_take | output | 1 | The pending torpedo is consumed this cycle |
| requeue | output | 1 | Write a copy of the retiring instruction back |
| hatch_open | output | 1 | Hatch state |
| z_flag | output | 1 | Outer count is zero |
| olc_val | output | CNT_W | Outer count |
| ilc_val | output | CNT_W | Inner count |
| ilc_inf | output | 1 | Inner count is infinite |

## Verification
The decision outputs (`od_exec`, `od_retire`, `torp_take`, `requeue`, `enq_push`) are combinational. They are due in the same cycle as the stimulus. The counters, torpedo slot and hatch are due one clock edge later. The bench drives inputs on the falling edge and compares every output against a behavioural model one nanosecond before the next rising edge. It then advances the model on that rising edge. As a result, a same-cycle result is compared against the model's pre-edge state, and a registered result shows up in the next cycle's comparison.

// File: rtl/ondeck_exec_pkg.sv
package ondeck_exec_pkg;

    typedef enum logic [1:0] {
        KIND_MOVE  = 2'b00,
        KIND_SET   = 2'b01,
        KIND_SHIFT = 2'b10,
        KIND_OTHER = 2'b11
    } od_kind_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_OUT_IMM  = 3'd1,
        OP_OUT_DATA = 3'd2,
        OP_OUT_DEC  = 3'd3,
        OP_IN_IMM   = 3'd4,
        OP_IN_INF   = 3'd5,
        OP_IN_DATA  = 3'd6,
        OP_RSVD     = 3'd7
    } cnt_op_e;

    typedef struct packed {
        logic exec;
        logic retire;
        logic torp_hit;
        logic move_step;
        logic move_end;
    } verdict_t;

    function automatic logic is_outer_op(cnt_op_e op);
        return (op == OP_OUT_IMM) || (op == OP_OUT_DATA) || (op == OP_OUT_DEC);
    endfunction

    function automatic logic is_inner_op(cnt_op_e op);
        return (op == OP_IN_IMM) || (op == OP_IN_INF) || (op == OP_IN_DATA);
    endfunction

endpackage

// File: rtl/ondeck_verdict.sv
module ondeck_verdict
    import ondeck_exec_pkg::*;
(
    input  logic     od_valid,
    input  od_kind_e kind,
    input  logic     immune,
    input  logic     pred_ok,
    input  logic     torp_pend,
    input  logic     inner_zero,
    input  logic     inner_one,
    input  logic     inner_inf,
    output verdict_t verdict
);

    logic is_move;
    assign is_move = (kind == KIND_MOVE);

    always_comb begin
        verdict = '0;
        if (od_valid) begin
            if (!pred_ok) begin
                verdict.retire = 1'b1;
            end else if (is_move && !immune && torp_pend) begin
                verdict.torp_hit = 1'b1;
                verdict.retire   = 1'b1;
            end else if (is_move) begin
                if (inner_inf) begin
                    verdict.exec = 1'b1;
                end else if (inner_zero) begin
                    verdict.retire   = 1'b1;
                    verdict.move_end = 1'b1;
                end else if (inner_one) begin
                    verdict.exec     = 1'b1;
                    verdict.retire   = 1'b1;
                    verdict.move_end = 1'b1;
                end else begin
                    verdict.exec      = 1'b1;
                    verdict.move_step = 1'b1;
                end
            end else begin
                verdict.exec   = 1'b1;
                verdict.retire = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ondeck_loop_counters.sv
module ondeck_loop_counters
    import ondeck_exec_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int IMM_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_fire,
    input  cnt_op_e           op,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] data,
    input  logic              move_step,
    input  logic              move_end,
    input  logic              torp_hit,
    output logic [CNT_W-1:0]  outer_q,
    output logic [CNT_W-1:0]  inner_q,
    output logic              inner_inf_q
);

    localparam int PAD_W = CNT_W - IMM_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] imm_ext;
    logic [CNT_W-1:0] data_low;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm};
        end else begin : g_nopad
            assign imm_ext = imm[CNT_W-1:0];
        end
    endgenerate

    assign data_low = data[CNT_W-1:0];

    logic [CNT_W-1:0] outer_d;
    logic [CNT_W-1:0] inner_d;
    logic             inf_d;

    always_comb begin
        outer_d = outer_q;
        if (torp_hit) begin
            outer_d = '0;
        end else if (set_fire && is_outer_op(op)) begin
            unique case (op)
                OP_OUT_IMM:  outer_d = imm_ext;
                OP_OUT_DATA: outer_d = data_low;
                OP_OUT_DEC:  outer_d = (outer_q == '0) ? '0 : outer_q - CNT_ONE;
                default:     outer_d = outer_q;
            endcase
        end
    end

    always_comb begin
        inner_d = inner_q;
        inf_d   = inner_inf_q;
        if (torp_hit || move_end) begin
            inner_d = CNT_ONE;
            inf_d   = 1'b0;
        end else if (move_step) begin
            inner_d = inner_q - CNT_ONE;
        end else if (set_fire && is_inner_op(op)) begin
            unique case (op)
                OP_IN_IMM: begin
                    inner_d = imm_ext;
                    inf_d   = 1'b0;
                end
                OP_IN_INF: begin
                    inf_d = 1'b1;
                end
                OP_IN_DATA: begin
                    inner_d = data_low;
                    inf_d   = 1'b0;
                end
                default: begin
                    inner_d = inner_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outer_q     <= '0;
            inner_q     <= CNT_ONE;
            inner_inf_q <= 1'b0;
        end else begin
            outer_q     <= outer_d;
            inner_q     <= inner_d;
            inner_inf_q <= inf_d;
        end
    end

endmodule

// File: rtl/ondeck_torpedo_slot.sv
module ondeck_torpedo_slot (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic take,
    output logic pending
);

    assign in_ready = !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (take) begin
            pending <= 1'b0;
        end else if (in_valid && in_ready) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/ondeck_hatch.sv
module ondeck_hatch (
    input  logic clk,
    input  logic rst,
    input  logic enq_valid,
    input  logic enq_is_tail,
    input  logic reopen,
    output logic enq_ready,
    output logic enq_push,
    output logic open_q
);

    logic seal;

    assign enq_ready = open_q;
    assign seal      = enq_valid && enq_is_tail && open_q;
    assign enq_push  = enq_valid && !enq_is_tail && open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b1;
        end else if (seal) begin
            open_q <= 1'b0;
        end else if (reopen) begin
            open_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ondeck_exec_ctl.sv
module ondeck_exec_ctl
    import ondeck_exec_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int IMM_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              od_valid,
    input  logic [1:0]        od_kind,
    input  logic              od_one_shot,
    input  logic              od_immune,
    input  logic              pred_ok,
    input  logic [2:0]        cnt_op,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic [DATA_W-1:0] latch_data,
    input  logic              torp_in_valid,
    output logic              torp_in_ready,
    input  logic              enq_valid,
    input  logic              enq_is_tail,
    output logic              enq_ready,
    output logic              enq_push,
    output logic              od_exec,
    output logic              od_retire,
    output logic              torp_take,
    output logic              requeue,
    output logic              hatch_open,
    output logic              z_flag,
    output logic [CNT_W-1:0]  olc_val,
    output logic [CNT_W-1:0]  ilc_val,
    output logic              ilc_inf
);

    od_kind_e kind;
    cnt_op_e  op;
    verdict_t verdict;
    logic     torp_pend;
    logic     set_fire;
    logic     reopen;

    assign kind = od_kind_e'(od_kind);
    assign op   = cnt_op_e'(cnt_op);

    ondeck_verdict u_verdict (
        .od_valid   (od_valid),
        .kind       (kind),
        .immune     (od_immune),
        .pred_ok    (pred_ok),
        .torp_pend  (torp_pend),
        .inner_zero (ilc_val == '0),
        .inner_one  (ilc_val == CNT_W'(1)),
        .inner_inf  (ilc_inf),
        .verdict    (verdict)
    );

    assign set_fire = verdict.exec && (kind == KIND_SET);

    ondeck_loop_counters #(
        .CNT_W  (CNT_W),
        .IMM_W  (IMM_W),
        .DATA_W (DATA_W)
    ) u_counters (
        .clk         (clk),
        .rst         (rst),
        .set_fire    (set_fire),
        .op          (op),
        .imm         (cnt_imm),
        .data        (latch_data),
        .move_step   (verdict.move_step),
        .move_end    (verdict.move_end),
        .torp_hit    (verdict.torp_hit),
        .outer_q     (olc_val),
        .inner_q     (ilc_val),
        .inner_inf_q (ilc_inf)
    );

    ondeck_torpedo_slot u_torp (
        .clk      (clk),
        .rst      (rst),
        .in_valid (torp_in_valid),
        .in_ready (torp_in_ready),
        .take     (verdict.torp_hit),
        .pending  (torp_pend)
    );

    assign z_flag = (olc_val == '0);
    assign reopen = od_valid && !od_one_shot && z_flag;

    ondeck_hatch u_hatch (
        .clk         (clk),
        .rst         (rst),
        .enq_valid   (enq_valid),
        .enq_is_tail (enq_is_tail),
        .reopen      (reopen),
        .enq_ready   (enq_ready),
        .enq_push    (enq_push),
        .open_q      (hatch_open)
    );

    assign od_exec   = verdict.exec;
    assign od_retire = verdict.retire;
    assign torp_take = verdict.torp_hit;
    assign requeue   = verdict.retire && !od_one_shot && !z_flag;

    initial begin
        if (CNT_W < IMM_W) $error("CNT_W must be at least IMM_W");
        if (DATA_W < CNT_W) $error("DATA_W must be at least CNT_W");
    end

endmodule

// File: rtl/ondeck_exec_ctl_chk.sv
module ondeck_exec_ctl_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             od_valid,
    input logic [1:0]       od_kind,
    input logic             od_one_shot,
    input logic             pred_ok,
    input logic             enq_valid,
    input logic             enq_is_tail,
    input logic             od_exec,
    input logic             od_retire,
    input logic             torp_take,
    input logic             requeue,
    input logic             enq_push,
    input logic             hatch_open,
    input logic             z_flag,
    input logic [CNT_W-1:0] ilc_val,
    input logic             ilc_inf,
    input logic             torp_in_ready
);

    p_skip_no_effect_r2: assert property (@(posedge clk) disable iff (rst)
        (od_valid && !pred_ok) |-> (od_retire && !od_exec && !torp_take));

    p_torp_resets_r3: assert property (@(posedge clk) disable iff (rst)
        torp_take |=> (z_flag && ilc_val == CNT_W'(1) && !ilc_inf && torp_in_ready));

    p_torp_not_exec_r3: assert property (@(posedge clk) disable iff (rst)
        torp_take |-> (!od_exec && od_retire && od_kind == 2'b00));

    p_move_end_one_r5: assert property (@(posedge clk) disable iff (rst)
        (od_valid && pred_ok && od_kind == 2'b00 && od_retire) |=> (ilc_val == CNT_W'(1) && !ilc_inf));

    p_inf_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (od_exec && od_kind == 2'b00 && ilc_inf) |-> !od_retire);

    p_requeue_rule_r10: assert property (@(posedge clk) disable iff (rst)
        requeue |-> (od_retire && !od_one_shot && !z_flag));

    p_push_gate_r12: assert property (@(posedge clk) disable iff (rst)
        enq_push |-> (hatch_open && !enq_is_tail));

    p_tail_seals_r12: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_is_tail && hatch_open) |=> !hatch_open);

    p_reopen_r13: assert property (@(posedge clk) disable iff (rst)
        (!hatch_open && od_valid && !od_one_shot && z_flag) |=> hatch_open);

endmodule

bind ondeck_exec_ctl ondeck_exec_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .od_valid      (od_valid),
    .od_kind       (od_kind),
    .od_one_shot   (od_one_shot),
    .pred_ok       (pred_ok),
    .enq_valid     (enq_valid),
    .enq_is_tail   (enq_is_tail),
    .od_exec       (od_exec),
    .od_retire     (od_retire),
    .torp_take     (torp_take),
    .requeue       (requeue),
    .enq_push      (enq_push),
    .hatch_open    (hatch_open),
    .z_flag        (z_flag),
    .ilc_val       (ilc_val),
    .ilc_inf       (ilc_inf),
    .torp_in_ready (torp_in_ready)
);

// File: tb/ondeck_exec_ctl_tb.sv
module ondeck_exec_ctl_tb_top;

    localparam int CNT_W  = 6;
    localparam int IMM_W  = 6;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              od_valid = 1'b0;
    logic [1:0]        od_kind = 2'b11;
    logic              od_one_shot = 1'b0;
    logic              od_immune = 1'b0;
    logic              pred_ok = 1'b1;
    logic [2:0]        cnt_op = 3'd0;
    logic [IMM_W-1:0]  cnt_imm = '0;
    logic [DATA_W-1:0] latch_data = '0;
    logic              torp_in_valid = 1'b0;
    logic              enq_valid = 1'b0;
    logic              enq_is_tail = 1'b0;
    logic              torp_in_ready, enq_ready, enq_push, od_exec, od_retire;
    logic              torp_take, requeue, hatch_open, z_flag, ilc_inf;
    logic [CNT_W-1:0]  olc_val, ilc_val;

    ondeck_exec_ctl #(.CNT_W(CNT_W), .IMM_W(IMM_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .od_valid(od_valid), .od_kind(od_kind),
        .od_one_shot(od_one_shot), .od_immune(od_immune), .pred_ok(pred_ok),
        .cnt_op(cnt_op), .cnt_imm(cnt_imm), .latch_data(latch_data),
        .torp_in_valid(torp_in_valid), .torp_in_ready(torp_in_ready),
        .enq_valid(enq_valid), .enq_is_tail(enq_is_tail), .enq_ready(enq_ready),
        .enq_push(enq_push), .od_exec(od_exec), .od_retire(od_retire),
        .torp_take(torp_take), .requeue(requeue), .hatch_open(hatch_open),
        .z_flag(z_flag), .olc_val(olc_val), .ilc_val(ilc_val), .ilc_inf(ilc_inf)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    // reference model state
    int m_olc = 0, m_ilc = 1;
    bit m_inf = 0, m_tp = 0, m_open = 1;
    // expected same-cycle values
    bit e_exec, e_ret, e_take, e_req, e_push;

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_comb();
        e_exec = 0; e_ret = 0; e_take = 0;
        if (od_valid) begin
            if (!pred_ok) e_ret = 1;
            else if (od_kind == 2'b00 && !od_immune && m_tp) begin
                e_take = 1; e_ret = 1;
            end else if (od_kind == 2'b00) begin
                if (m_inf) e_exec = 1;
                else if (m_ilc == 0) e_ret = 1;
                else begin
                    e_exec = 1;
                    e_ret = (m_ilc == 1);
                end
            end else begin
                e_exec = 1; e_ret = 1;
            end
        end
        e_req  = e_ret && !od_one_shot && (m_olc != 0);
        e_push = enq_valid && !enq_is_tail && m_open;
    endtask

    task automatic model_edge();
        bit reop;
        reop = od_valid && !od_one_shot && (m_olc == 0);
        if (e_take) begin
            m_olc = 0; m_ilc = 1; m_inf = 0;
        end else if (od_valid && pred_ok && od_kind == 2'b00) begin
            if (!m_inf) begin
                if (m_ilc <= 1) m_ilc = 1;
                else m_ilc = m_ilc - 1;
            end
        end else if (e_exec && od_kind == 2'b01) begin
            case (cnt_op)
                3'd1: m_olc = cnt_imm;
                3'd2: m_olc = latch_data % 64;
                3'd3: m_olc = (m_olc > 0) ? m_olc - 1 : 0;
                3'd4: begin m_ilc = cnt_imm; m_inf = 0; end
                3'd5: m_inf = 1;
                3'd6: begin m_ilc = latch_data % 64; m_inf = 0; end
                default: ;
            endcase
        end
        if (e_take) m_tp = 0;
        else if (torp_in_valid && !m_tp) m_tp = 1;
        if (enq_valid && enq_is_tail && m_open) m_open = 0;
        else if (reop) m_open = 1;
    endtask

    // called at a falling edge with inputs already set
    task automatic step(string tag);
        #4;
        model_comb();
        chk(tag, "od_exec", od_exec, e_exec);
        chk(tag, "od_retire", od_retire, e_ret);
        chk(tag, "torp_take", torp_take, e_take);
        chk(tag, "requeue", requeue, e_req);
        chk(tag, "enq_push", enq_push, e_push);
        chk(tag, "enq_ready", enq_ready, m_open);
        chk(tag, "hatch_open", hatch_open, m_open);
        chk(tag, "torp_in_ready", torp_in_ready, !m_tp);
        chk(tag, "olc_val", olc_val, m_olc);
        chk(tag, "z_flag", z_flag, m_olc == 0);
        chk(tag, "ilc_val", ilc_val, m_ilc);
        chk(tag, "ilc_inf", ilc_inf, m_inf);
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        od_valid = 0; od_kind = 2'b11; od_one_shot = 0; od_immune = 0;
        pred_ok = 1; cnt_op = 3'd0; cnt_imm = '0; torp_in_valid = 0;
        enq_valid = 0; enq_is_tail = 0;
    endtask

    task automatic do_set(int op, int imm, string tag);
        idle();
        od_valid = 1; od_kind = 2'b01; cnt_op = op[2:0]; cnt_imm = imm[IMM_W-1:0];
        od_one_shot = 1;
        step(tag);
    endtask

    task automatic do_move(bit imm_bit, bit os, string tag);
        idle();
        od_valid = 1; od_kind = 2'b00; od_immune = imm_bit; od_one_shot = os;
        step(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        step("R1");
        // R8 / R9: loads from the immediate
        do_set(1, 5, "R8");
        do_set(4, 3, "R9");
        // R5 + R10: three-cycle move, requeued because outer count is 5
        do_move(0, 0, "R5");
        do_move(0, 0, "R5");
        do_move(0, 0, "R10");
        // R10: one-shot retire never requeues
        idle(); od_valid = 1; od_kind = 2'b10; od_one_shot = 1; step("R10");
        // R8: decrement
        do_set(3, 0, "R8");
        // R8 / R9: loads from the data latch
        latch_data = 16'hAB42;
        idle(); latch_data = 16'hAB42; od_valid = 1; od_kind = 2'b01; cnt_op = 3'd2; step("R8");
        idle(); latch_data = 16'h0000; od_valid = 1; od_kind = 2'b01; cnt_op = 3'd6; step("R9");
        // R6: inner count 0 retires without executing
        do_move(0, 0, "R6");
        // R2: predicate false changes nothing
        idle(); od_valid = 1; od_kind = 2'b01; cnt_op = 3'd1; cnt_imm = 6'd9; pred_ok = 0; step("R2");
        idle(); od_valid = 1; od_kind = 2'b00; pred_ok = 0; step("R2");
        // R9: reserved code has no effect
        do_set(7, 0, "R9");
        // R8: decrement to zero, then saturate
        do_set(1, 1, "R8");
        do_set(3, 0, "R8");
        do_set(3, 0, "R8");
        do_set(1, 4, "R8");
        // R11: torpedo arrives and is held
        idle(); torp_in_valid = 1; step("R11");
        idle(); torp_in_valid = 1; step("R11");
        // R4: immune move and a non-move leave the torpedo pending
        do_move(1, 0, "R4");
        do_set(4, 2, "R4");
        do_move(1, 0, "R4");
        do_move(1, 0, "R4");
        // R3: non-immune move is torpedoed
        do_set(4, 5, "R3");
        do_move(0, 0, "R3");
        idle(); step("R3");
        // R7: infinite move runs until a torpedo
        do_set(1, 7, "R7");
        do_set(5, 0, "R7");
        for (int i = 0; i < 5; i++) do_move(0, 0, "R7");
        idle(); od_valid = 1; od_kind = 2'b00; torp_in_valid = 1; step("R7");
        do_move(0, 0, "R3");
        idle(); step("R3");
        // R12: tail seals, later entries blocked
        idle(); enq_valid = 1; enq_is_tail = 0; step("R12");
        idle(); enq_valid = 1; enq_is_tail = 1; step("R12");
        idle(); enq_valid = 1; enq_is_tail = 0; step("R12");
        // R13: one-shot does not reopen, requeueable with zero does
        idle(); od_valid = 1; od_kind = 2'b10; od_one_shot = 1; step("R13");
        idle(); od_valid = 1; od_kind = 2'b10; od_one_shot = 0; step("R13");
        idle(); enq_valid = 1; step("R13");
        // R12: seal wins over a same-cycle reopen
        idle(); enq_valid = 1; enq_is_tail = 1; od_valid = 1; od_kind = 2'b10; step("R12");
        idle(); enq_valid = 1; step("R12");
        // R13: nonzero outer count does not reopen
        do_set(1, 2, "R13");
        idle(); od_valid = 1; od_kind = 2'b10; step("R13");
        do_set(3, 0, "R13");
        do_set(3, 0, "R13");
        idle(); od_valid = 1; od_kind = 2'b11; step("R13");
        idle(); step("R13");
        finish_run();
    end

endmodule